// File: doc/BRIEF.md
# Ready/Busy and Interrupt Pin Driver

This block drives a storage card's shared status pin, whose meaning and polarity depend on the host interface mode. In memory mode the pin reports readiness: it stays low (busy) after power-up or reset until internal initialization signals completion, and afterwards it follows the internal busy status. In I/O mode the pin is an active-low interrupt request. It can run as a level interrupt, which holds the pin low until software reads status, or as a pulse interrupt, which strobes the pin low for a fixed number of cycles. In True IDE mode the pin is an active-high interrupt request.

The interface mode is sampled on every clock edge, so a mode change reaches the pin only through registers. The pin itself is a flop output. It changes only just after a rising clock edge and cannot glitch while the mode changes. The hardware reset input is active high in memory and I/O mode and active low in True IDE mode. A power-on reset input clears the block in every mode.

Top module: `rdy_irq_pin`

## Requirements
- R1: While reset is active, the pin is driven to the idle level of the mode presented on `modeSel`. That level is low for memory and True IDE mode and high for I/O mode. `modeSel` encodings: 0 = memory, 1 = I/O, 2 = True IDE, 3 = memory.
- R2: In memory mode, after reset the pin stays low until `initDone` has been seen high on a clock edge.
- R3: In memory mode, once initialization is done, the pin is high when `busy` is low and low when `busy` is high. The response arrives two rising edges after the input is applied.
- R4: In I/O level mode (`pulseMode` = 0), an `irqEvent` makes an interrupt pending. While it is pending and not masked, the pin is low.
- R5: A `statusRead` strobe clears a pending interrupt. If `irqEvent` and `statusRead` fall in the same cycle, the interrupt stays pending.
- R6: In I/O pulse mode (`pulseMode` = 1), an unmasked `irqEvent` drives the pin low for exactly `PULSE_CYCLES` cycles (default 8), then releases it high.
- R7: In True IDE mode the pin is high while an interrupt is pending and unmasked, and low otherwise.
- R8: While `irqDisable` is high, the interrupt output is suppressed and no pulse is started. A pending interrupt is still retained and appears once `irqDisable` is cleared.
- R9: `hostReset` is active high when `modeSel` selects memory or I/O, and active low when it selects True IDE. `porN` low always resets. Reset clears initialization status and the pending interrupt.
- R10: A change on `modeSel` reaches the pin exactly two rising edges later. Code 3 behaves as memory mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low |
| hostReset | input | 1 | Host reset; polarity depends on selected mode |
| modeSel | input | 2 | Interface mode: 0 memory, 1 I/O, 2 True IDE, 3 memory |
| pulseMode | input | 1 | I/O interrupt style: 1 pulse, 0 level |
| irqDisable | input | 1 | Interrupt mask |
| initDone | input | 1 | Internal initialization finished |
| busy | input | 1 | Internal busy status |
| irqEvent | input | 1 | One-cycle interrupt-cause strobe |
| statusRead | input | 1 | One-cycle status-read strobe; clears pending interrupt |
| pinOut | output | 1 | Ready/busy or interrupt pin level |

## Verification
Every input is captured at one rising edge, and the pin register reflects it at the following edge. Each result is therefore due two edges after the stimulus, and the pulse interrupt occupies the `PULSE_CYCLES` edges after that. The bench drives inputs at falling edges. A behavioural model updates on each rising edge and is compared with the pin at every falling edge. Targeted checks are placed at the falling edge after the second rising edge, so none sample a cycle early. The pulse check counts low samples over a window longer than the pulse, which catches both a short and a long strobe.

// File: rtl/rdy_irq_pkg.sv
package rdy_irq_pkg;

  typedef enum logic [1:0] {
    MODE_MEM = 2'd0,
    MODE_IO  = 2'd1,
    MODE_IDE = 2'd2
  } ifMode_t;

  typedef struct packed {
    logic clearAll;
    logic setInit;
    logic setPend;
    logic clrPend;
    logic loadPulse;
  } ctrlStrobes_t;

  function automatic ifMode_t mapMode(input logic [1:0] sel);
    case (sel)
      2'd1:    return MODE_IO;
      2'd2:    return MODE_IDE;
      default: return MODE_MEM;
    endcase
  endfunction

endpackage

// File: rtl/rdy_irq_ctrl.sv
module rdy_irq_ctrl
  import rdy_irq_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         hostReset,
  input  logic [1:0]   modeSel,
  input  logic         pulseMode,
  input  logic         irqDisable,
  input  logic         initDone,
  input  logic         irqEvent,
  input  logic         statusRead,
  output ctrlStrobes_t strb,
  output ifMode_t      modeIn,
  output ifMode_t      modeQ,
  output logic         pulseModeQ,
  output logic         maskQ
);

  logic hostResetActive;

  // The mode on the pins selects how the host reset is read.
  always_comb begin
    modeIn          = mapMode(modeSel);
    hostResetActive = (modeIn == MODE_IDE) ? !hostReset : hostReset;
  end

  always_comb begin
    strb.clearAll  = !porN || hostResetActive;
    strb.setInit   = initDone;
    strb.setPend   = irqEvent;
    strb.clrPend   = statusRead && !irqEvent;
    strb.loadPulse = irqEvent && !irqDisable && pulseMode && (modeIn == MODE_IO);
  end

  always_ff @(posedge clk) begin
    if (strb.clearAll) begin
      modeQ      <= modeIn;
      pulseModeQ <= 1'b0;
      maskQ      <= 1'b0;
    end else begin
      modeQ      <= modeIn;
      pulseModeQ <= pulseMode;
      maskQ      <= irqDisable;
    end
  end

endmodule

// File: rtl/rdy_irq_dp.sv
module rdy_irq_dp
  import rdy_irq_pkg::*;
#(
  parameter int PULSE_CYCLES = 8
) (
  input  logic         clk,
  input  ctrlStrobes_t strb,
  input  ifMode_t      modeIn,
  input  ifMode_t      modeQ,
  input  logic         pulseModeQ,
  input  logic         maskQ,
  input  logic         busy,
  output logic         pinQ
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYCLES);

  logic             initOk;
  logic             busyQ;
  logic             irqPend;
  logic [CNT_W-1:0] pulseCnt;
  logic             irqLive;
  logic             pinNext;

  always_comb begin
    irqLive = irqPend && !maskQ;
    case (modeQ)
      MODE_IO:  pinNext = pulseModeQ ? (pulseCnt == '0) : !irqLive;
      MODE_IDE: pinNext = irqLive;
      default:  pinNext = initOk && !busyQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.clearAll) begin
      initOk   <= 1'b0;
      busyQ    <= 1'b0;
      irqPend  <= 1'b0;
      pulseCnt <= '0;
      pinQ     <= (modeIn == MODE_IO);
    end else begin
      pinQ  <= pinNext;
      busyQ <= busy;
      if (strb.setInit) initOk <= 1'b1;
      if (strb.setPend)      irqPend <= 1'b1;
      else if (strb.clrPend) irqPend <= 1'b0;
      if (strb.loadPulse)          pulseCnt <= PULSE_LOAD;
      else if (pulseCnt != '0)     pulseCnt <= pulseCnt - 1'b1;
    end
  end

  // R2: memory pin stays busy until initialization completes
  assert_init_hold_R2: assert property (@(posedge clk) disable iff (strb.clearAll)
    (modeQ == MODE_MEM && !initOk) |=> !pinQ);

  // R4: level interrupt in I/O mode pulls the pin low
  assert_level_irq_R4: assert property (@(posedge clk) disable iff (strb.clearAll)
    (modeQ == MODE_IO && !pulseModeQ && irqPend && !maskQ) |=> !pinQ);

  // R5: a status read without a new event leaves nothing pending
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (strb.clearAll)
    strb.clrPend |=> !irqPend);

  // R6: pulse strobe counts down one per cycle
  assert_pulse_count_R6: assert property (@(posedge clk) disable iff (strb.clearAll)
    (pulseCnt != '0 && !strb.loadPulse) |=> (pulseCnt == CNT_W'($past(pulseCnt) - 1'b1)));

  // R7: True IDE interrupt is active high
  assert_ide_irq_R7: assert property (@(posedge clk) disable iff (strb.clearAll)
    (modeQ == MODE_IDE && irqPend && !maskQ) |=> pinQ);

endmodule

// File: rtl/rdy_irq_pin.sv
module rdy_irq_pin
  import rdy_irq_pkg::*;
#(
  parameter int PULSE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       hostReset,
  input  logic [1:0] modeSel,
  input  logic       pulseMode,
  input  logic       irqDisable,
  input  logic       initDone,
  input  logic       busy,
  input  logic       irqEvent,
  input  logic       statusRead,
  output logic       pinOut
);

  ctrlStrobes_t strb;
  ifMode_t      modeIn;
  ifMode_t      modeQ;
  logic         pulseModeQ;
  logic         maskQ;

  rdy_irq_ctrl uCtrl (
    .clk        (clk),
    .porN       (porN),
    .hostReset  (hostReset),
    .modeSel    (modeSel),
    .pulseMode  (pulseMode),
    .irqDisable (irqDisable),
    .initDone   (initDone),
    .irqEvent   (irqEvent),
    .statusRead (statusRead),
    .strb       (strb),
    .modeIn     (modeIn),
    .modeQ      (modeQ),
    .pulseModeQ (pulseModeQ),
    .maskQ      (maskQ)
  );

  rdy_irq_dp #(.PULSE_CYCLES(PULSE_CYCLES)) uDp (
    .clk        (clk),
    .strb       (strb),
    .modeIn     (modeIn),
    .modeQ      (modeQ),
    .pulseModeQ (pulseModeQ),
    .maskQ      (maskQ),
    .busy       (busy),
    .pinQ       (pinOut)
  );

endmodule

// File: tb/tb_rdy_irq_pin.sv
module tb_rdy_irq_pin;

  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       porN = 1'b0, hostReset = 1'b0, pulseMode = 1'b0, irqDisable = 1'b0;
  logic       initDone = 1'b0, busy = 1'b0, irqEvent = 1'b0, statusRead = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic       pinOut;

  rdy_irq_pin #(.PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .porN(porN), .hostReset(hostReset), .modeSel(modeSel),
    .pulseMode(pulseMode), .irqDisable(irqDisable), .initDone(initDone),
    .busy(busy), .irqEvent(irqEvent), .statusRead(statusRead), .pinOut(pinOut)
  );

  int    checks = 0, errors = 0, cyc = 0;
  string curReq = "R1";
  bit    done = 0;

  // behavioural reference model
  int mMode = 0, mCnt = 0;
  bit mPin = 0, mInit = 0, mBusy = 0, mPend = 0, mPulse = 0, mMask = 0;

  function automatic int selToMode(input logic [1:0] s);
    return (s == 2'd1) ? 1 : (s == 2'd2) ? 2 : 0;
  endfunction

  always @(posedge clk) begin
    int  m;
    bit  rst;
    bit  live;
    m    = selToMode(modeSel);
    rst  = !porN || ((m == 2) ? !hostReset : hostReset);
    cyc++;
    if (rst) begin
      mPin = (m == 1); mInit = 0; mBusy = 0; mPend = 0; mCnt = 0;
      mPulse = 0; mMask = 0;
    end else begin
      live = mPend && !mMask;
      if (mMode == 1)      mPin = mPulse ? (mCnt == 0) : !live;
      else if (mMode == 2) mPin = live;
      else                 mPin = mInit && !mBusy;
      if (initDone) mInit = 1;
      mBusy = busy;
      if (irqEvent && !irqDisable && pulseMode && m == 1) mCnt = PULSE;
      else if (mCnt > 0) mCnt--;
      if (irqEvent) mPend = 1;
      else if (statusRead) mPend = 0;
      mPulse = pulseMode; mMask = irqDisable;
    end
    mMode = m;
  end

  always @(negedge clk) begin
    if (cyc >= 1 && !done) begin
      checks++;
      if (pinOut !== mPin) begin
        errors++;
        $display("FAIL %s model compare: actual=%0b expected=%0b", curReq, pinOut, mPin);
      end
    end
  end

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countLows(input int window, output int lows);
    lows = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (pinOut === 1'b0) lows++;
    end
  endtask

  task automatic strobeEvent();
    irqEvent = 1; step(1); irqEvent = 0;
  endtask

  task automatic strobeRead();
    statusRead = 1; step(1); statusRead = 0;
  endtask

  initial begin
    int lows;
    // R1: reset idle levels
    curReq = "R1";
    step(3);
    checkBit("R1 memory reset idle low", pinOut, 1'b0);
    modeSel = 2'd1; step(2);
    checkBit("R1 I/O reset idle high", pinOut, 1'b1);
    modeSel = 2'd0; step(2);

    // R2: busy until initialization done
    curReq = "R2";
    porN = 1; step(5);
    checkBit("R2 low before initDone", pinOut, 1'b0);

    // R3: ready/busy following
    curReq = "R3";
    initDone = 1; step(1); initDone = 0;
    checkBit("R3 not yet after one edge", pinOut, 1'b0);
    step(1);
    checkBit("R3 ready two edges after initDone", pinOut, 1'b1);
    busy = 1; step(2);
    checkBit("R3 busy drives low", pinOut, 1'b0);
    busy = 0; step(2);
    checkBit("R3 idle drives high", pinOut, 1'b1);

    // R4: level interrupt
    curReq = "R4";
    modeSel = 2'd1; pulseMode = 0; step(3);
    checkBit("R4 idle I/O high", pinOut, 1'b1);
    strobeEvent(); step(1);
    checkBit("R4 level interrupt low", pinOut, 1'b0);
    step(5);
    checkBit("R4 level interrupt held", pinOut, 1'b0);

    // R5: status read clears, event wins
    curReq = "R5";
    strobeRead(); step(1);
    checkBit("R5 read clears", pinOut, 1'b1);
    irqEvent = 1; statusRead = 1; step(1); irqEvent = 0; statusRead = 0; step(1);
    checkBit("R5 event wins over read", pinOut, 1'b0);
    strobeRead(); step(1);
    checkBit("R5 cleared again", pinOut, 1'b1);

    // R8: masking
    curReq = "R8";
    irqDisable = 1; step(1);
    strobeEvent(); step(3);
    checkBit("R8 masked level stays high", pinOut, 1'b1);
    irqDisable = 0; step(2);
    checkBit("R8 pending retained after unmask", pinOut, 1'b0);
    strobeRead(); step(1);

    // R6: pulse interrupt
    curReq = "R6";
    pulseMode = 1; step(2);
    strobeEvent();
    countLows(20, lows);
    checkBit("R6 pulse width equals PULSE_CYCLES", lows == PULSE, 1'b1);
    if (lows != PULSE) $display("FAIL R6 pulse lows actual=%0d expected=%0d", lows, PULSE);
    curReq = "R8";
    irqDisable = 1; step(1);
    strobeEvent();
    countLows(20, lows);
    checkBit("R8 masked pulse not started", lows == 0, 1'b1);
    irqDisable = 0; pulseMode = 0;
    strobeRead(); step(2);

    // R7: True IDE interrupt
    curReq = "R7";
    modeSel = 2'd2; hostReset = 1; step(3);
    checkBit("R7 IDE idle low", pinOut, 1'b0);
    strobeEvent(); step(1);
    checkBit("R7 IDE interrupt high", pinOut, 1'b1);
    strobeRead(); step(1);
    checkBit("R7 IDE cleared low", pinOut, 1'b0);

    // R9: reset polarity
    curReq = "R9";
    strobeEvent(); step(1);
    hostReset = 0; step(1); hostReset = 1; step(3);
    checkBit("R9 active-low reset in IDE clears pending", pinOut, 1'b0);
    modeSel = 2'd0; hostReset = 0; step(1);
    initDone = 1; step(1); initDone = 0; step(2);
    checkBit("R9 memory ready with reset released", pinOut, 1'b1);
    hostReset = 1; step(1); hostReset = 0; step(3);
    checkBit("R9 active-high reset clears init", pinOut, 1'b0);
    initDone = 1; step(1); initDone = 0; step(2);

    // R10: mode code 3 and switch timing
    curReq = "R10";
    modeSel = 2'd3; step(3);
    checkBit("R10 code 3 acts as memory", pinOut, 1'b1);
    modeSel = 2'd2; hostReset = 1; step(1);
    checkBit("R10 old mode after one edge", pinOut, 1'b1);
    step(1);
    checkBit("R10 new mode after two edges", pinOut, 1'b0);
    step(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule